// File: doc/BRIEF.md
# Open-LED Detect and Lockout

This block gathers an open-LED indication for each of 48 constant-current sink channels. Every channel has an analog comparator that reports its output voltage is below the selected detection threshold, which means the LED string is open or the output is shorted to ground. The block synchronises each comparator bit and accepts it only while that channel is actually driven. It confirms a fault only when two consecutive synchronised samples agree, and it accumulates confirmed faults for the current display segment. At each segment boundary it freezes the accumulated flags into a readback latch, so a serial readback never sees a half-updated set of flags.

A lockout mode can be switched on and off by the line-reset command. While lockout is on, every channel that gets flagged is forced dark by a sticky mask, and only a block reset clears that mask. This stops a failed channel from producing the trailing-light artifact on a multiplexed panel. The 2-bit threshold select is not interpreted here. It is passed through to the analog comparators.

Top module: `led_open_guard`

## Requirements
- R1: After a synchronous reset, `flag_snap` is all zero, lockout is off and no channel is masked, so `ch_en` equals `pwm_on`.
- R2: A channel that is enabled and whose `cmp_low` stays high for at least two consecutive clocks shows 1 in its `flag_snap` bit after the next `seg_end`.
- R3: A channel whose `ch_en` is 0 reports 0 in `flag_snap`, whatever its `cmp_low` does.
- R4: A `cmp_low` pulse that lasts a single clock never sets a flag.
- R5: `flag_snap` changes only on the clock edge where `seg_end` is 1. The working flags are cleared at that edge, so each snapshot covers only one segment.
- R6: `thr_sel_out` equals `thr_sel_in` for all four codes 0 to 3.
- R7: A `lock_wr` pulse with `lock_val` = 1 turns lockout on. While lockout is on, every newly flagged channel is masked and its `ch_en` is forced to 0.
- R8: A `lock_wr` pulse with `lock_val` = 0 turns lockout off. Channels flagged while lockout is off stay unmasked.
- R9: A mask bit, once set, stays set when lockout is turned off and across later segments. Only `rst` clears it.
- R10: For every channel that is not masked, `ch_en` follows `pwm_on` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_on | input | 48 | Per-channel PWM enable from the grayscale engine |
| cmp_low | input | 48 | Asynchronous comparator outputs, 1 = output voltage below threshold |
| thr_sel_in | input | 2 | Detection threshold select from the configuration latch |
| seg_end | input | 1 | One-cycle pulse at the end of each display segment |
| lock_wr | input | 1 | Line-reset command strobe that updates the lockout setting |
| lock_val | input | 1 | Lockout setting written by `lock_wr` (1 = on) |
| thr_sel_out | output | 2 | Threshold select passed to the comparators |
| ch_en | output | 48 | Per-channel output enable after lockout masking |
| flag_snap | output | 48 | Readback latch of open flags, loaded into the shift register |

## Verification
On every cycle, the in-RTL assertions check four things:
- A mask bit never drops and appears only while lockout is on.
- The snapshot moves only at a segment boundary.
- A working flag rises only after two consecutive qualified hits.
- A working flag never rises for a channel that was not driven.

Only the bench's scenarios can show the end-to-end results:
- The flags produced by specific on/comparator patterns.
- The rejection of a single-clock glitch.
- The clearing of flags between segments.
- That a locked channel stays dark after lockout is switched off, until reset.

// File: rtl/lodg_pkg.sv
package lodg_pkg;

    // Default geometry of the detector
    parameter int unsigned LODG_NUM_CH     = 48;
    parameter int unsigned LODG_THR_W      = 2;
    parameter int unsigned LODG_SYNC_DEPTH = 2;

    // Per-cycle control carried from the ports into the datapath
    typedef struct packed {
        logic seg_end;
        logic lock_wr;
        logic lock_val;
    } lodg_ctl_t;

    // Lockout setting after a possible line-reset update
    function automatic logic next_lock(input logic cur, input lodg_ctl_t c);
        return c.lock_wr ? c.lock_val : cur;
    endfunction

endpackage

// File: rtl/lodg_pipe.sv
module lodg_pipe #(
    parameter int unsigned W     = 48,
    parameter int unsigned DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < int'(DEPTH); k++) stage[k] <= '0;
        end else begin
            stage[0] <= d;
            for (int k = 1; k < int'(DEPTH); k++) stage[k] <= stage[k-1];
        end
    end

    assign q = stage[DEPTH-1];
endmodule

// File: rtl/lodg_qualify.sv
module lodg_qualify
    import lodg_pkg::*;
#(
    parameter int unsigned N = 48
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] cmp_s,
    input  logic [N-1:0] en_s,
    input  lodg_ctl_t    ctl,
    output logic [N-1:0] confirm,
    output logic [N-1:0] snap
);
    logic [N-1:0] hit;
    logic [N-1:0] hit_q;
    logic [N-1:0] live;

    // A sample counts only when the channel was driven in the aligned cycle
    assign hit     = cmp_s & en_s;
    assign confirm = hit & hit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q <= '0;
            live  <= '0;
            snap  <= '0;
        end else begin
            hit_q <= hit;
            if (ctl.seg_end) begin
                snap <= live | confirm;
                live <= '0;
            end else begin
                live <= live | confirm;
            end
        end
    end

    // R5
    snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(ctl.seg_end) |-> $stable(snap));

    // R4
    two_hits_chk: assert property (@(posedge clk) disable iff (rst)
        ((live & ~$past(live)) & ~($past(hit) & $past(hit, 2))) == '0);

    // R3
    off_chan_chk: assert property (@(posedge clk) disable iff (rst)
        ((live & ~$past(live)) & ~$past(en_s)) == '0);
endmodule

// File: rtl/lodg_mask.sv
module lodg_mask
    import lodg_pkg::*;
#(
    parameter int unsigned N = 48
) (
    input  logic         clk,
    input  logic         rst,
    input  lodg_ctl_t    ctl,
    input  logic [N-1:0] confirm,
    output logic [N-1:0] mask
);
    logic lock_on;

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_on <= 1'b0;
            mask    <= '0;
        end else begin
            lock_on <= next_lock(lock_on, ctl);
            if (lock_on) mask <= mask | confirm;
        end
    end

    // R9
    mask_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(mask) & ~mask) == '0);

    // R8
    mask_needs_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (|(mask & ~$past(mask))) |-> $past(lock_on));
endmodule

// File: rtl/led_open_guard.sv
module led_open_guard
    import lodg_pkg::*;
#(
    parameter int unsigned NUM_CH     = LODG_NUM_CH,
    parameter int unsigned THR_W      = LODG_THR_W,
    parameter int unsigned SYNC_DEPTH = LODG_SYNC_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] pwm_on,
    input  logic [NUM_CH-1:0] cmp_low,
    input  logic [THR_W-1:0]  thr_sel_in,
    input  logic              seg_end,
    input  logic              lock_wr,
    input  logic              lock_val,
    output logic [THR_W-1:0]  thr_sel_out,
    output logic [NUM_CH-1:0] ch_en,
    output logic [NUM_CH-1:0] flag_snap
);
    lodg_ctl_t         ctl;
    logic [NUM_CH-1:0] cmp_s;
    logic [NUM_CH-1:0] en_s;
    logic [NUM_CH-1:0] confirm;
    logic [NUM_CH-1:0] mask;

    assign ctl         = '{seg_end: seg_end, lock_wr: lock_wr, lock_val: lock_val};
    assign thr_sel_out = thr_sel_in;
    assign ch_en       = pwm_on & ~mask;

    // Two-flop synchroniser for the comparator bits
    lodg_pipe #(.W(NUM_CH), .DEPTH(SYNC_DEPTH)) u_cmp_sync (
        .clk(clk), .rst(rst), .d(cmp_low), .q(cmp_s)
    );

    // Matching delay on the effective enable, so that each sample is qualified by its own cycle
    lodg_pipe #(.W(NUM_CH), .DEPTH(SYNC_DEPTH)) u_en_dly (
        .clk(clk), .rst(rst), .d(ch_en), .q(en_s)
    );

    lodg_qualify #(.N(NUM_CH)) u_qual (
        .clk(clk), .rst(rst), .cmp_s(cmp_s), .en_s(en_s), .ctl(ctl),
        .confirm(confirm), .snap(flag_snap)
    );

    lodg_mask #(.N(NUM_CH)) u_mask (
        .clk(clk), .rst(rst), .ctl(ctl), .confirm(confirm), .mask(mask)
    );

    // R7
    locked_dark_chk: assert property (@(posedge clk) disable iff (rst)
        (|(mask & $past(mask))) |-> ((ch_en & $past(mask)) == '0));
endmodule

// File: tb/led_open_guard_tb_top.sv
module led_open_guard_tb_top;
    localparam int N = 48;
    typedef logic [N-1:0] vec_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    vec_t       pwm_on = '0;
    vec_t       cmp_low = '0;
    logic [1:0] thr_sel_in = '0;
    logic       seg_end = 1'b0;
    logic       lock_wr = 1'b0;
    logic       lock_val = 1'b0;
    logic [1:0] thr_sel_out;
    vec_t       ch_en;
    vec_t       flag_snap;

    int   n_vec  = 0;
    int   n_fail = 0;
    vec_t exp_q[$];
    string req_q[$];
    vec_t exp_mask = '0;
    logic exp_lock = 1'b0;
    vec_t last_snap = '0;

    always #5 clk = ~clk;

    led_open_guard dut_i (
        .clk(clk), .rst(rst), .pwm_on(pwm_on), .cmp_low(cmp_low),
        .thr_sel_in(thr_sel_in), .seg_end(seg_end), .lock_wr(lock_wr),
        .lock_val(lock_val), .thr_sel_out(thr_sel_out), .ch_en(ch_en),
        .flag_snap(flag_snap)
    );

    task automatic chk(input string req, input vec_t act, input vec_t exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pops the expected snapshot after each segment boundary
    initial begin
        forever begin
            @(posedge clk);
            if (!rst && seg_end === 1'b1) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    chk("R5 unexpected snapshot", flag_snap, last_snap);
                end else begin
                    automatic vec_t e = exp_q.pop_front();
                    automatic string r = req_q.pop_front();
                    chk(r, flag_snap, e);
                    last_snap = e;
                end
            end
        end
    end

    task automatic set_lock(input logic v);
        @(negedge clk);
        lock_wr = 1'b1; lock_val = v;
        @(negedge clk);
        lock_wr = 1'b0; lock_val = 1'b0;
        exp_lock = v;
    endtask

    // Driver: one display segment, expected snapshot pushed to the scoreboard
    task automatic segment(input string req, input vec_t on, input vec_t cmp, input bit glitch);
        automatic vec_t e = glitch ? vec_t'(0) : (on & cmp & ~exp_mask);
        @(negedge clk);
        pwm_on = on; cmp_low = cmp;
        repeat (glitch ? 1 : 6) @(negedge clk);
        cmp_low = '0;
        repeat (4) @(negedge clk);
        chk("R5 snapshot held mid-segment", flag_snap, last_snap);
        exp_q.push_back(e);
        req_q.push_back(req);
        seg_end = 1'b1;
        @(negedge clk);
        seg_end = 1'b0;
        if (exp_lock) exp_mask = exp_mask | e;
        @(negedge clk);
        #1;
        chk("R7 R10 ch_en after segment", ch_en, pwm_on & ~exp_mask);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        pwm_on = '1;
        #1;
        chk("R1 ch_en after reset", ch_en, '1);
        chk("R1 snapshot after reset", flag_snap, '0);

        for (int t = 0; t < 4; t++) begin
            @(negedge clk);
            thr_sel_in = 2'(t);
            #1;
            chk("R6 threshold pass-through", vec_t'(thr_sel_out), vec_t'(t));
        end

        segment("R2 R3 mixed on/cmp", 48'hFFFF_0000_FFFF, 48'h00F0_00F0_0F0F, 1'b0);
        segment("R5 flags cleared per segment", '1, '0, 1'b0);
        segment("R4 single-cycle glitch", '1, 48'hAAAA_5555_AAAA, 1'b1);
        set_lock(1'b0);
        segment("R8 lockout off no masking", '1, 48'h0000_0000_0008, 1'b0);
        set_lock(1'b1);
        segment("R7 lockout on flags", '1, 48'h8000_0000_0010, 1'b0);
        segment("R7 R3 locked channels report 0", '1, 48'h8000_0000_0F10, 1'b0);
        set_lock(1'b0);
        segment("R9 mask kept after lockout off", 48'h0123_4567_89AB, 48'h0000_1000_0000, 1'b0);

        @(negedge clk);
        pwm_on = 48'hFEDC_BA98_7654;
        #1;
        chk("R10 R9 ch_en follows pwm_on with mask", ch_en, 48'hFEDC_BA98_7654 & ~exp_mask);

        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        exp_mask = '0; exp_lock = 1'b0; last_snap = '0;
        pwm_on = '1;
        #1;
        chk("R9 R1 reset clears mask", ch_en, '1);
        chk("R1 reset clears snapshot", flag_snap, '0);

        set_lock(1'b0);
        segment("R2 after reset detection works", '1, 48'h8000_0000_0010, 1'b0);

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) chk("R5 pending snapshots", vec_t'(exp_q.size()), '0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R1..all actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule